// File: doc/BRIEF.md
# Byte-Wide Configuration Memory Fetch Sequencer

This block fetches configuration bytes from an external byte-wide memory without help from a processor. It presents an address and an active-low memory enable, captures each returned byte at one fixed point in the byte period, and sends the byte out serially with its own configuration clock. That clock runs at eight times the address rate, so each address stays on the bus for one byte slot of sixteen system clocks.

A static mode input picks the direction of the walk. With the mode low, fetching starts at the bottom of memory and counts up. With the mode high, it starts at the top and counts down. This lets the block share a memory with a processor that boots from either end. The fetch is pipelined one byte deep: while one byte is shifted out, the next is read. The first slot after reset only primes the pipeline, and the configuration clock stays idle during it. A done input from the downstream controller stops the whole sequence until the next reset.

Top module: `cfg_prom_seq`

## Requirements
- R1: The address `mem_addr_o` is ADDR_W bits wide (16 by default). With `mode_hi_i` = 0 the first slot after reset presents 0x0000. The address then rises by one at the start of each later slot, and a slot is 16 clock cycles long.
- R2: With `mode_hi_i` = 1 the first slot presents the all-ones address (0xFFFF at 16 bits). The address then falls by one per slot. `mode_hi_i` is held constant while the block runs.
- R3: The address count wraps modulo 2^ADDR_W: ascending goes from all-ones to zero, and descending goes from zero to all-ones.
- R4: `cclk_o` is low in slot 0. From slot 1 on, it is low in even cycles of the slot (0, 2, ..., 14) and high in odd cycles, which gives 8 pulses per address. It is always low in the cycle in which the address changes.
- R5: `mem_en_no` is low from reset until done is taken. It rises only on the edge after `done_i` was sampled high.
- R6: The byte on `mem_data_i` is captured only on the clock edge that ends cycle 12 of a slot. Its value at any other edge has no effect.
- R7: The byte captured in slot k is shifted out in slot k+1, most significant bit first. Bit i (i = 0 is the MSB) is on `dout_o` during cycles 2i and 2i+1 of the slot. `dout_o` never changes while `cclk_o` is high.
- R8: A clock edge that samples `done_i` high stops the block from that edge onward. `mem_enno` goes high, the address freezes and `cclk_o` stays low. This holds until reset, even if `done_i` falls again.
- R9: During and right after reset, `mem_addr_o` shows the start address for the mode, and `cclk_o`, `dout_o` and `mem_en_no` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_hi_i | input | 1 | 0: count up from zero, 1: count down from all-ones |
| done_i | input | 1 | Stop request from the downstream controller |
| mem_data_i | input | DATA_W | Byte returned by the memory |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_en_no | output | 1 | Memory enable, active low |
| cclk_o | output | 1 | Configuration clock |
| dout_o | output | 1 | Serial data, MSB first |

## Verification
Two instances run side by side under both modes for more than 64 slots. One uses a 16-bit address, which shows that the start values and the step direction differ between modes. The other uses a 6-bit address, which crosses the wrap point in each direction. The memory model returns a byte derived from the address at cycle 12 of each slot and the bit-inverted byte at every other cycle. A capture at the wrong cycle therefore shows up as flipped serial bits, not as a silent pass. Address, clock phase and every serial bit are compared in every cycle against values the bench computes from the cycle count. The run then takes done, releases it again, and confirms that the stop holds.

// File: rtl/cfg_prom_pkg.sv
package cfg_prom_pkg;
  typedef enum logic {
    DIR_ASCEND  = 1'b0,
    DIR_DESCEND = 1'b1
  } addr_dir_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/cfg_prom_timer.sv
module cfg_prom_timer #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SAMPLE_TICK = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  output logic run_o,
  output logic sample_o,
  output logic load_o,
  output logic shift_o,
  output logic cclk_o,
  output logic stop_o
);
  localparam int unsigned TICKS  = 2 * DATA_W;
  localparam int unsigned TICK_W = $clog2(TICKS);
  localparam logic [TICK_W-1:0] LAST_T = TICK_W'(TICKS - 1);
  localparam logic [TICK_W-1:0] SMPL_T = TICK_W'(SAMPLE_TICK);

  logic [TICK_W-1:0] tick_q;
  logic              primed_q;
  logic              stop_q;

  assign run_o = !stop_q && !done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q   <= '0;
      primed_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      if (done_i) stop_q <= 1'b1;
      if (run_o) begin
        tick_q <= (tick_q == LAST_T) ? '0 : tick_q + 1'b1;
        if (tick_q == LAST_T) primed_q <= 1'b1;
      end
    end
  end

  assign sample_o = run_o && (tick_q == SMPL_T);
  assign load_o   = run_o && (tick_q == LAST_T);
  // shift on the end of each high phase, except the last which reloads
  assign shift_o  = run_o && primed_q && tick_q[0] && (tick_q != LAST_T);
  assign cclk_o   = primed_q && !stop_q && tick_q[0];
  assign stop_o   = stop_q;
endmodule

// File: rtl/cfg_prom_addr.sv
module cfg_prom_addr #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_hi_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  import cfg_prom_pkg::*;

  logic [ADDR_W-1:0] cnt_q;
  addr_dir_e         dir;

  assign dir = addr_dir_e'(mode_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  // top-down walk is the bitwise complement of the bottom-up count
  assign addr_o = (dir == DIR_DESCEND) ? ~cnt_q : cnt_q;
endmodule

// File: rtl/cfg_prom_shift.sv
module cfg_prom_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              dout_o
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sreg_q <= '0;
    end else begin
      if (sample_i) hold_q <= data_i;
      if (load_i) sreg_q <= hold_q;
      else if (shift_i) sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
    end
  end

  assign dout_o = sreg_q[DATA_W-1];
endmodule

// File: rtl/cfg_prom_seq.sv
module cfg_prom_seq #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = cfg_prom_pkg::BYTE_W,
  parameter int unsigned SAMPLE_TICK = 2 * DATA_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_hi_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_en_no,
  output logic              cclk_o,
  output logic              dout_o
);
  logic run, sample, load, shift, stop;

  cfg_prom_timer #(
    .DATA_W     (DATA_W),
    .SAMPLE_TICK(SAMPLE_TICK)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_i),
    .run_o   (run),
    .sample_o(sample),
    .load_o  (load),
    .shift_o (shift),
    .cclk_o  (cclk_o),
    .stop_o  (stop)
  );

  cfg_prom_addr #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_hi_i(mode_hi_i),
    .adv_i    (load),
    .addr_o   (mem_addr_o)
  );

  cfg_prom_shift #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .load_i  (load),
    .shift_i (shift),
    .data_i  (mem_data_i),
    .dout_o  (dout_o)
  );

  logic unused_run;
  assign unused_run = run;
  assign mem_en_no  = stop;
endmodule

// File: rtl/cfg_prom_seq_chk.sv
module cfg_prom_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_hi_i,
  input logic              done_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_en_no,
  input logic              cclk_o,
  input logic              dout_o
);
  p_step_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mem_addr_o) && $stable(mode_hi_i) && !mode_hi_i)
      |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

  p_step_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mem_addr_o) && $stable(mode_hi_i) && mode_hi_i)
      |-> mem_addr_o == ADDR_W'($past(mem_addr_o) - 1'b1));

  p_addr_cclk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mem_addr_o) && $stable(mode_hi_i)) |-> !cclk_o);

  p_en_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_en_no) |-> $past(done_i));

  p_dout_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> $stable(dout_o));

  p_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_i) |-> (mem_en_no && !cclk_o));

  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_no && $past(mem_en_no) && $stable(mode_hi_i)) |-> $stable(mem_addr_o));
endmodule

bind cfg_prom_seq cfg_prom_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_hi_i (mode_hi_i),
  .done_i    (done_i),
  .mem_addr_o(mem_addr_o),
  .mem_en_no (mem_en_no),
  .cclk_o    (cclk_o),
  .dout_o    (dout_o)
);

// File: tb/cfg_prom_seq_tb_top.sv
module cfg_prom_seq_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SMALL_W    = 6;
  localparam int  SAMPLE_T   = 12;
  localparam int  RUN        = 1100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode;
  logic        done;
  logic [7:0]  data_big, data_sml;
  logic [15:0] addr_big;
  logic [SMALL_W-1:0] addr_sml;
  logic        en_big, en_sml, cclk_big, cclk_sml, dout_big, dout_sml;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_prom_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_hi_i(mode), .done_i(done),
    .mem_data_i(data_big), .mem_addr_o(addr_big), .mem_en_no(en_big),
    .cclk_o(cclk_big), .dout_o(dout_big)
  );

  cfg_prom_seq #(.ADDR_W(SMALL_W)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_hi_i(mode), .done_i(done),
    .mem_data_i(data_sml), .mem_addr_o(addr_sml), .mem_en_no(en_sml),
    .cclk_o(cclk_sml), .dout_o(dout_sml)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd29;
    return p ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] exp_addr(input logic md, input int slot, input int w);
    logic [15:0] v;
    logic [15:0] mask;
    v    = 16'(slot);
    mask = 16'((32'd1 << w) - 1);
    if (md) v = ~v;
    return v & mask;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // memory answers correctly only at the capture cycle; inverted otherwise
  task automatic drive_mem(input int n);
    bit good;
    good     = (n % 16) == SAMPLE_T;
    data_big = good ? mem_byte(addr_big) : ~mem_byte(addr_big);
    data_sml = good ? mem_byte(16'(addr_sml)) : ~mem_byte(16'(addr_sml));
  endtask

  task automatic check_cycle(input logic md, input int n);
    int  slot, t;
    logic [7:0] b_big, b_sml;
    logic e_cclk, e_dbig, e_dsml;
    slot   = n / 16;
    t      = n % 16;
    e_cclk = (slot >= 1) && (t % 2 == 1);
    e_dbig = 1'b0;
    e_dsml = 1'b0;
    if (slot >= 1) begin
      b_big  = mem_byte(exp_addr(md, slot - 1, 16));
      b_sml  = mem_byte(exp_addr(md, slot - 1, SMALL_W));
      e_dbig = b_big[7 - t / 2];
      e_dsml = b_sml[7 - t / 2];
    end
    chk(md ? "R2 address 16b" : "R1 address 16b", 32'(addr_big), 32'(exp_addr(md, slot, 16)));
    chk("R3 wrapping address 6b", 32'(addr_sml), 32'(exp_addr(md, slot, SMALL_W)));
    chk("R4 cclk 16b", 32'(cclk_big), 32'(e_cclk));
    chk("R4 cclk 6b", 32'(cclk_sml), 32'(e_cclk));
    chk("R7 (R6) dout 16b", 32'(dout_big), 32'(e_dbig));
    chk("R7 (R6) dout 6b", 32'(dout_sml), 32'(e_dsml));
    chk("R5 enable low", 32'({en_big, en_sml}), 32'd0);
  endtask

  task automatic run_mode(input logic md);
    logic [15:0] a_big;
    logic [SMALL_W-1:0] a_sml;
    rst_n = 1'b0;
    done  = 1'b0;
    mode  = md;
    repeat (3) @(negedge clk);
    chk("R9 reset address 16b", 32'(addr_big), 32'(exp_addr(md, 0, 16)));
    chk("R9 reset outputs", 32'({cclk_big, dout_big, en_big, cclk_sml, dout_sml, en_sml}), 32'd0);
    rst_n = 1'b1;
    drive_mem(0);
    for (int n = 1; n <= RUN; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(md, n);
      drive_mem(n);
    end
    a_big = addr_big;
    a_sml = addr_sml;
    done  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    done = 1'b0;
    for (int k = 0; k < 24; k++) begin
      chk("R8 enable high", 32'({en_big, en_sml}), 32'd3);
      chk("R8 cclk idle", 32'({cclk_big, cclk_sml}), 32'd0);
      chk("R8 address frozen 16b", 32'(addr_big), 32'(a_big));
      chk("R8 address frozen 6b", 32'(addr_sml), 32'(a_sml));
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    done     = 1'b0;
    mode     = 1'b0;
    data_big = '0;
    data_sml = '0;
    run_mode(1'b0);
    run_mode(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule